// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets a MAC's software reach the management registers of an external PHY over the two-wire MDC/MDIO bus, using clause-22 frames. Software packs a complete management frame into one 32-bit word and writes it to the management register. The block then emits a 32-bit run of ones, followed by the word, most significant bit first. For a read, the block lets go of MDIO from the turnaround onward. It shifts the 16 bits returned by the PHY into the low half of the same register.

Software polls an idle flag in the status register before it issues an operation and again to learn that the operation has finished. A port-enable bit in the control register gates all bus activity, and clearing it stops a frame that is under way. A configuration bit selects the MDC divisor, 48 or 64 system clocks per MDC period. The divisor is taken when a frame starts.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset the control, configuration and management registers read 0, the status register reads 0x4 (idle), and MDC, the MDIO output enable and the bus activity are all low.
- R2: A started frame drives 32 ones, then management word bits 31 down to 0 in that order, one bit per MDC period, for exactly 64 MDC rising edges. The word layout is: 31:30 start code, 29:28 opcode, 27:23 PHY address, 22:18 register number, 17:16 turnaround, 15:0 data.
- R3: The MDC period is 48 system clocks when configuration bit 0 (address 1) is 0, and 64 when it is 1. MDC stays low while no frame runs.
- R4: MDIO and its output enable change only while MDC is low; they are held through every MDC high phase so the PHY samples them on the rising edge.
- R5: When word bits 29:28 are 10 (read), the output enable is low from the turnaround bit 17 through data bit 0. At the end of the frame, bits 15:0 of the management register (address 3) hold the 16 bits sampled from MDIO on MDC rising edges, first sample in bit 15, and bits 31:16 are unchanged. Any other opcode drives all 64 bits and leaves the register unchanged.
- R6: A read from an absent PHY, whose MDIO line stays high, returns 0xFFFF in bits 15:0.
- R7: Status register (address 2) bit 2 reads 0 from the clock after an accepted management write until the frame ends, and 1 otherwise.
- R8: With control register (address 0) bit 4 clear, a write to the management register stores the word but starts no frame: the idle flag stays 1 and MDC and the output enable stay low.
- R9: A write to the management register while a frame runs is ignored: the register and the frame on the wire keep the first word.
- R10: Clearing control bit 4 during a frame stops it within two clocks: the output enable and MDC fall, the idle flag returns to 1, and a stopped read leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (peripheral) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Register word address: 0 control, 1 config, 2 status, 3 management |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data output value |
| mdio_oe_o | output | 1 | Management data output enable (1 = block drives MDIO) |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
The frame engine runs under both divisors, with write words whose fields reach all-ones, all-zeros and alternating patterns. These words separate a bit-order or field-shift fault from a preamble or length fault. Reads return PHY data with an isolated top and bottom bit (0x8001), all zeros, alternating patterns and an absent PHY. These values show capture order, an off-by-one sample window and the pulled-high default. They also show that the upper word bits survive write-back. Directed cases cover a write issued mid-frame, a disable issued mid-frame and a write issued while the port is disabled. In each case the wire activity and the register contents are observed afterwards.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  // register word addresses
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_CFG  = 2'd1;
  localparam logic [1:0] ADR_STAT = 2'd2;
  localparam logic [1:0] ADR_MGMT = 2'd3;

  // bit positions software relies on
  localparam int CTRL_EN_BIT   = 4;
  localparam int CFG_SLOW_BIT  = 0;
  localparam int STAT_IDLE_BIT = 2;

  // management word fields
  localparam int         OP_HI      = 29;
  localparam int         OP_LO      = 28;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam int         TA_TOP_BIT = 17;

  typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_FAST = 48,
  parameter int DIV_SLOW = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow_sel,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW      = $clog2(DIV_MAX + 1);
  localparam logic [CW-1:0] FAST_C = CW'(DIV_FAST);
  localparam logic [CW-1:0] SLOW_C = CW'(DIV_SLOW);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic          slow_q, slow_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [CW-1:0] div_cur, half_cur;

  always_comb begin
    div_cur  = slow_q ? SLOW_C : FAST_C;
    half_cur = div_cur >> 1;
    // divisor is frozen for the length of a frame
    slow_nxt = run ? slow_q : slow_sel;
    cnt_nxt  = '0;
    if (run) begin
      cnt_nxt = (cnt_q == div_cur - ONE_C) ? '0 : cnt_q + ONE_C;
    end
    rise_stb = run && (cnt_q == half_cur - ONE_C);
    fall_stb = run && (cnt_q == div_cur - ONE_C);
    mdc      = run && (cnt_q >= half_cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      slow_q <= slow_nxt;
      cnt_q  <= cnt_nxt;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int WORD_W  = 32,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic [WORD_W-1:0] start_word,
  input  logic              mdio_i,
  input  logic              rise_stb,
  input  logic              fall_stb,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              wb_valid,
  output logic [DATA_W-1:0] wb_data
);
  localparam int FRAME_LEN = PRE_LEN + WORD_W;
  localparam int IW        = $clog2(FRAME_LEN);
  localparam int WSEL      = $clog2(WORD_W);
  localparam logic [IW-1:0] PRE_I     = IW'(PRE_LEN);
  localparam logic [IW-1:0] LAST_I    = IW'(FRAME_LEN - 1);
  localparam logic [IW-1:0] RELEASE_I = IW'(PRE_LEN + WORD_W - 1 - TA_TOP_BIT);
  localparam logic [IW-1:0] CAPTURE_I = IW'(PRE_LEN + WORD_W - DATA_W);
  localparam logic [IW-1:0] ONE_I     = IW'(1);

  eng_state_e        state_q, state_nxt;
  logic [IW-1:0]     idx_q, idx_nxt;
  logic [WORD_W-1:0] word_q, word_nxt;
  logic              rd_q, rd_nxt;
  logic [DATA_W-1:0] shift_q, shift_nxt;
  logic [WSEL-1:0]   bit_sel;

  always_comb begin
    state_nxt = state_q;
    idx_nxt   = idx_q;
    word_nxt  = word_q;
    rd_nxt    = rd_q;
    shift_nxt = shift_q;
    wb_valid  = 1'b0;
    case (state_q)
      ENG_IDLE: begin
        if (start && enable) begin
          state_nxt = ENG_SHIFT;
          idx_nxt   = '0;
          word_nxt  = start_word;
          rd_nxt    = (start_word[OP_HI:OP_LO] == OP_READ);
          shift_nxt = '0;
        end
      end
      default: begin
        if (!enable) begin
          state_nxt = ENG_IDLE;
        end else begin
          if (rise_stb && rd_q && (idx_q >= CAPTURE_I)) begin
            shift_nxt = {shift_q[DATA_W-2:0], mdio_i};
          end
          if (fall_stb) begin
            if (idx_q == LAST_I) begin
              state_nxt = ENG_IDLE;
              wb_valid  = rd_q;
            end else begin
              idx_nxt = idx_q + ONE_I;
            end
          end
        end
      end
    endcase
  end

  always_comb begin
    busy    = (state_q == ENG_SHIFT);
    bit_sel = WSEL'(LAST_I - idx_q);
    mdio_o  = (!busy || idx_q < PRE_I) ? 1'b1 : word_q[bit_sel];
    mdio_oe = busy && !(rd_q && (idx_q >= RELEASE_I));
    wb_data = shift_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      idx_q   <= '0;
      word_q  <= '0;
      rd_q    <= 1'b0;
      shift_q <= '0;
    end else begin
      state_q <= state_nxt;
      idx_q   <= idx_nxt;
      word_q  <= word_nxt;
      rd_q    <= rd_nxt;
      shift_q <= shift_nxt;
    end
  end
endmodule

// File: rtl/mdio_mgmt_regs.sv
module mdio_mgmt_regs
  import mdio_mgmt_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              wb_valid,
  input  logic [DATA_W-1:0] wb_data,
  output logic              port_en,
  output logic              slow_sel,
  output logic              start,
  output logic [WORD_W-1:0] mgmt_word
);
  logic              en_q, en_nxt;
  logic              slow_q, slow_nxt;
  logic [WORD_W-1:0] word_q, word_nxt;
  logic              mgmt_wr;

  always_comb begin
    mgmt_wr  = bus_wr && (bus_addr == ADR_MGMT) && !busy;
    en_nxt   = en_q;
    slow_nxt = slow_q;
    word_nxt = word_q;
    if (bus_wr && bus_addr == ADR_CTRL) en_nxt   = bus_wdata[CTRL_EN_BIT];
    if (bus_wr && bus_addr == ADR_CFG)  slow_nxt = bus_wdata[CFG_SLOW_BIT];
    if (wb_valid) word_nxt[DATA_W-1:0] = wb_data;
    if (mgmt_wr)  word_nxt = bus_wdata;
    start = mgmt_wr && en_q;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_CTRL: bus_rdata[CTRL_EN_BIT]   = en_q;
      ADR_CFG:  bus_rdata[CFG_SLOW_BIT]  = slow_q;
      ADR_STAT: bus_rdata[STAT_IDLE_BIT] = !busy;
      default:  bus_rdata = word_q;
    endcase
    port_en   = en_q;
    slow_sel  = slow_q;
    mgmt_word = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      slow_q <= 1'b0;
      word_q <= '0;
    end else begin
      en_q   <= en_nxt;
      slow_q <= slow_nxt;
      word_q <= word_nxt;
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int PRE_LEN  = 32,
  parameter int DIV_FAST = 48,
  parameter int DIV_SLOW = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int WORD_W = 32;
  localparam int DATA_W = 16;

  logic [1:0]        rst_sync_q;
  logic              srst_n;
  logic              busy, start, port_en, slow_sel;
  logic              rise_stb, fall_stb, wb_valid;
  logic [DATA_W-1:0] wb_data;
  logic [WORD_W-1:0] mgmt_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  mdio_mgmt_regs #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(srst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .wb_valid(wb_valid), .wb_data(wb_data),
    .port_en(port_en), .slow_sel(slow_sel), .start(start), .mgmt_word(mgmt_word)
  );

  mdio_mdc_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_mdc (
    .clk(clk), .rst_n(srst_n), .run(busy), .slow_sel(slow_sel),
    .mdc(mdc_o), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(srst_n), .enable(port_en), .start(start), .start_word(bus_wdata),
    .mdio_i(mdio_i), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe_o),
    .wb_valid(wb_valid), .wb_data(wb_data)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_addr,
  input logic        bus_wr,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o,
  input logic        start,
  input logic        busy,
  input logic        port_en,
  input logic        wb_valid,
  input logic [31:0] mgmt_word
);
  // R7
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R8
  disabled_port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!mdio_oe_o && !mdc_o));

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bus_wr && bus_addr == 2'd3 && !wb_valid) |=> $stable(mgmt_word));

  // R4
  mdio_held_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  // R2
  frame_opens_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mdio_oe_o && mdio_o));

  // R3
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc_o && !mdio_oe_o));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n(srst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
  .start(start), .busy(busy), .port_en(port_en), .wb_valid(wb_valid),
  .mgmt_word(mgmt_word)
);

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        mdc_o, mdio_o, mdio_oe_o, mdio_i;

  always #2.5 clk = ~clk;

  mdio_mgmt_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // ---------------- PHY model ----------------
  int          rise_cnt = 0;
  int          base     = 0;
  int          t0 = 0, t1 = 0;
  logic [63:0] cap, oe_cap;
  logic        phy_present = 1'b1;
  logic        cur_read    = 1'b0;
  logic [15:0] phy_data    = 16'h0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge mdc_o) begin
    automatic int k = rise_cnt - base;
    if (k >= 0 && k < 64) begin
      cap[63-k]    <= mdio_o;
      oe_cap[63-k] <= mdio_oe_o;
    end
    if (k == 0) t0 <= cyc;
    if (k == 1) t1 <= cyc;
    rise_cnt <= rise_cnt + 1;
  end

  always_comb begin
    automatic int k = rise_cnt - base;
    mdio_i = 1'b1;
    if (phy_present && cur_read && k >= 48 && k < 64) mdio_i = phy_data[63-k];
  end

  // R4 monitor: data must hold while MDC stays high
  int   r4_bad = 0;
  logic prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (mdc_o && prev_mdc && (mdio_o !== prev_o || mdio_oe_o !== prev_oe)) r4_bad <= r4_bad + 1;
    prev_mdc <= mdc_o;
    prev_o   <= mdio_o;
    prev_oe  <= mdio_oe_o;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 20000; n++) begin
      bus_read(2'd2, s);
      if (s[2]) break;
    end
  endtask

  function automatic logic [31:0] mk_word(input logic rd, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, (rd ? 16'h0 : d)};
  endfunction

  // {slow, read, phy[5], reg[5], data[16], present}
  localparam logic [28:0] VECS [8] = '{
    {1'b0, 1'b0, 5'd1,  5'd0,  16'hA5C3, 1'b1},
    {1'b1, 1'b0, 5'd31, 5'd31, 16'hFFFF, 1'b1},
    {1'b0, 1'b1, 5'd5,  5'd2,  16'h1234, 1'b1},
    {1'b1, 1'b1, 5'd0,  5'd1,  16'h8001, 1'b1},
    {1'b0, 1'b1, 5'd3,  5'd3,  16'h4C4C, 1'b0},
    {1'b0, 1'b0, 5'd0,  5'd0,  16'h0000, 1'b1},
    {1'b1, 1'b1, 5'd17, 5'd9,  16'h0000, 1'b1},
    {1'b0, 1'b1, 5'd10, 5'd21, 16'h5A5A, 1'b1}
  };

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] r, w, w2;
    int          rc;
    rst_n = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(2'd0, r); chk(r == 32'h0, "R1 control reset", r, 0);
    bus_read(2'd1, r); chk(r == 32'h0, "R1 config reset", r, 0);
    bus_read(2'd2, r); chk(r == 32'h4, "R1 status reset", r, 4);
    bus_read(2'd3, r); chk(r == 32'h0, "R1 management reset", r, 0);
    chk(!mdc_o && !mdio_oe_o && rise_cnt == 0, "R1 bus quiet", {mdc_o, mdio_oe_o}, 0);

    bus_write(2'd0, 32'h10);

    // table walk
    for (int i = 0; i < 8; i++) begin
      logic        slow, rd, pres;
      logic [4:0]  phy, rg;
      logic [15:0] d, expd;
      {slow, rd, phy, rg, d, pres} = VECS[i];
      bus_write(2'd1, {31'h0, slow});
      w = mk_word(rd, phy, rg, d);
      cur_read = rd; phy_present = pres; phy_data = d;
      base = rise_cnt;
      bus_write(2'd3, w);
      bus_read(2'd2, r);
      chk(r[2] == 1'b0, "R7 idle clear while shifting", r, 0);
      wait_idle();
      chk(rise_cnt - base == 64, "R2 MDC edge count", rise_cnt - base, 64);
      chk(t1 - t0 == (slow ? 64 : 48), "R3 MDC period", t1 - t0, slow ? 64 : 48);
      bus_read(2'd3, r);
      if (!rd) begin
        chk(cap == {32'hFFFF_FFFF, w}, "R2 write frame bits", cap, {32'hFFFF_FFFF, w});
        chk(oe_cap == '1, "R5 write frame fully driven", oe_cap, '1);
        chk(r == w, "R5 write leaves register", r, w);
      end else begin
        expd = pres ? d : 16'hFFFF;
        chk(cap[63:18] == {32'hFFFF_FFFF, w[31:18]}, "R2 read frame header", cap[63:18], {32'hFFFF_FFFF, w[31:18]});
        chk(oe_cap == {{46{1'b1}}, 18'h0}, "R5 read release window", oe_cap, {{46{1'b1}}, 18'h0});
        chk(r == {w[31:16], expd}, pres ? "R5 read data in place" : "R6 absent PHY all ones",
            r, {w[31:16], expd});
      end
      bus_read(2'd2, r);
      chk(r == 32'h4, "R7 idle after frame", r, 4);
    end

    // R9 write while busy
    bus_write(2'd1, 32'h0);
    w = mk_word(1'b0, 5'd9, 5'd4, 16'h0F0F);
    w2 = mk_word(1'b0, 5'd22, 5'd7, 16'hF0F0);
    cur_read = 1'b0; base = rise_cnt;
    bus_write(2'd3, w);
    repeat (100) @(negedge clk);
    bus_write(2'd3, w2);
    bus_read(2'd3, r);
    chk(r == w, "R9 busy write ignored register", r, w);
    wait_idle();
    chk(cap == {32'hFFFF_FFFF, w}, "R9 frame keeps first word", cap, {32'hFFFF_FFFF, w});

    // R10 disable mid frame
    w = mk_word(1'b1, 5'd2, 5'd6, 16'h0);
    cur_read = 1'b1; phy_present = 1'b1; phy_data = 16'h3C3C; base = rise_cnt;
    bus_write(2'd3, w);
    repeat (2900) @(negedge clk);
    bus_write(2'd0, 32'h0);
    @(negedge clk);
    chk(!mdio_oe_o && !mdc_o, "R10 abort releases bus", {mdc_o, mdio_oe_o}, 0);
    bus_read(2'd2, r);
    chk(r == 32'h4, "R10 abort idle", r, 4);
    rc = rise_cnt;
    repeat (300) @(negedge clk);
    chk(rise_cnt == rc, "R10 no MDC after abort", rise_cnt, rc);
    bus_read(2'd3, r);
    chk(r == w, "R10 aborted read leaves register", r, w);

    // R8 write while disabled
    w = mk_word(1'b0, 5'd12, 5'd13, 16'hBEEF);
    rc = rise_cnt;
    bus_write(2'd3, w);
    bus_read(2'd2, r);
    chk(r == 32'h4, "R8 disabled stays idle", r, 4);
    repeat (300) @(negedge clk);
    chk(rise_cnt == rc && !mdio_oe_o, "R8 disabled no frame", rise_cnt, rc);
    bus_read(2'd3, r);
    chk(r == w, "R8 disabled word stored", r, w);

    chk(r4_bad == 0, "R4 MDIO held during MDC high", r4_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule